// File: doc/BRIEF.md
# In-Place Word Order Reverser

This engine reorders the words of a zero-terminated byte string so that the last word comes first and the first word comes last. The string stays in the same bytes of a single-port byte RAM that the engine owns while it runs. A space byte (value 32) separates the words. The zero byte that ends the string is never written.

A start pulse loads the string address. The engine then works in three phases:

- It reads forward until it finds the zero byte, which gives the string length.
- It reverses every byte of the string.
- It walks the reversed string and reverses each word back in place.

Each reversal swaps the bytes at a low pointer and a high pointer and moves the two pointers toward each other. The RAM has one cycle of read latency. Every swap takes two read cycles followed by two write cycles. A one-cycle done pulse marks the end.

Top module: `word_reverser`

## Requirements
- R1: Writes only touch addresses from the start address up to, but not including, the first zero byte at or after it. The zero byte and every byte outside that range keep their values.
- R2: On completion the words (runs of non-space bytes) appear in reverse order, each spelled forwards. For example, "I Love Lucy" becomes "Lucy Love I".
- R3: Only byte value 32 separates words. Runs of spaces, and leading or trailing spaces, come out mirrored, so " x yz" becomes "yz x ".
- R4: A string whose first byte is zero finishes with done and no RAM write.
- R5: A one-character string finishes with no write. One-character words cost no writes in the per-word phase.
- R6: A start pulse while the engine is busy is ignored. The run in progress completes unchanged and only one done pulse is produced.
- R7: done is high for exactly one cycle and only while busy is high. busy rises in the cycle after an accepted start. No write occurs while busy is low.
- R8: Each swap is one pair of consecutive write cycles. The total write count is 2*floor(L/2) for the full reversal (L = string length), plus 2*floor(W/2) summed over every word of length W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_addr | input | AW | Address of the first string byte |
| mem_addr | output | AW | RAM byte address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after the address |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the engine is the only master of the RAM. They also assume that a zero byte lies between the start address and the top of the address space, so the range bounded by the terminator is well defined.

The bench keeps within these assumptions. It places every string well below the top of its 256-byte RAM model, writes the model only while the engine is idle, and surrounds each string with sentinel bytes so that a stray write shows up.

// File: rtl/word_reverser.sv
module word_reverser #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int SEP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done
);
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_RD, S_SCAN_CHK, S_TEST, S_RD_LO, S_RD_HI,
    S_WR_LO, S_WR_HI, S_WORD_RD, S_WORD_CHK, S_FIN
  } state_t;

  localparam logic [DW-1:0] SEP_B  = DW'(SEP);
  localparam logic [DW-1:0] ZERO_B = '0;

  state_t        st;
  logic [AW-1:0] base_q, end_q, ptr, ws, lo, hi;
  logic [DW-1:0] hold;
  logic          word_phase, last_word;
  logic          is_term, is_sep;

  assign is_term = (mem_rdata == ZERO_B);
  assign is_sep  = (mem_rdata == SEP_B);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign mem_we  = (st == S_WR_LO) || (st == S_WR_HI);
  assign mem_wdata = (st == S_WR_LO) ? mem_rdata : hold;

  always_comb begin
    case (st)
      S_RD_LO, S_WR_LO: mem_addr = lo;
      S_RD_HI, S_WR_HI: mem_addr = hi;
      default:          mem_addr = ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0;
      end_q <= '0;
      ptr <= '0;
      ws <= '0;
      lo <= '0;
      hi <= '0;
      hold <= '0;
      word_phase <= 1'b0;
      last_word <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= start_addr;
          end_q <= start_addr;
          ptr <= start_addr;
          word_phase <= 1'b0;
          last_word <= 1'b0;
          st <= S_SCAN_RD;
        end
        S_SCAN_RD: st <= S_SCAN_CHK;
        S_SCAN_CHK: begin
          if (is_term) begin
            end_q <= ptr;
            lo <= base_q;
            hi <= ptr - AW'(1);
            st <= (ptr == base_q) ? S_FIN : S_TEST;
          end else begin
            ptr <= ptr + AW'(1);
            st <= S_SCAN_RD;
          end
        end
        S_TEST: begin
          if (lo < hi) st <= S_RD_LO;
          else if (!word_phase) begin
            word_phase <= 1'b1;
            ptr <= base_q;
            ws <= base_q;
            st <= S_WORD_RD;
          end else if (last_word) st <= S_FIN;
          else begin
            ptr <= ptr + AW'(1);
            ws <= ptr + AW'(1);
            st <= S_WORD_RD;
          end
        end
        S_RD_LO: st <= S_RD_HI;
        S_RD_HI: begin
          hold <= mem_rdata;
          st <= S_WR_LO;
        end
        S_WR_LO: st <= S_WR_HI;
        S_WR_HI: begin
          lo <= lo + AW'(1);
          hi <= hi - AW'(1);
          st <= S_TEST;
        end
        S_WORD_RD: st <= S_WORD_CHK;
        S_WORD_CHK: begin
          if (is_term || is_sep) begin
            last_word <= is_term;
            lo <= ws;
            hi <= (ptr == ws) ? ws : ptr - AW'(1);
            st <= S_TEST;
          end else begin
            ptr <= ptr + AW'(1);
            st <= S_WORD_RD;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_reverser_chk.sv
module word_reverser_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] end_q
);
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= base_q) && (mem_addr < end_q)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R7
  AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R6
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> mem_we); // R8
  AST_WRITE_PAIR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |=> !mem_we); // R8
endmodule

bind word_reverser word_reverser_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_addr(mem_addr), .base_q(base_q), .end_q(end_q)
);

// File: tb/word_reverser_tb.sv
`timescale 1ns/1ps
module word_reverser_tb;
  localparam int AW = 8;
  localparam int NV = 6;
  localparam int BASE = 40;
  localparam logic [7:0] FILL = 8'hA5;

  localparam string VIN [NV] = '{"I Love Lucy", "ab", "hello world",
                                 " x yz", "abc", "a b c d"};
  localparam string VEXP [NV] = '{"Lucy Love I", "ab", "world hello",
                                  "yz x ", "abc", "d c b a"};
  localparam int VWR [NV] = '{18, 4, 18, 6, 4, 6};

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic mem_we, busy, done;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [256];
  int checks = 0, errors = 0, wcount = 0, dcount = 0;

  always #4 clk = ~clk;

  word_reverser #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    mem_rdata <= ram[mem_addr];
    if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (done) dcount <= dcount + 1;
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic load(input int a, input string s);
    for (int i = 0; i < 256; i++) ram[i] = FILL;
    for (int i = 0; i < s.len(); i++) ram[a+i] = s[i];
    ram[a+s.len()] = 8'h00;
  endtask

  function automatic string grab(input int a, input int n);
    string r = "";
    for (int i = 0; i < n; i++) r = {r, $sformatf("%c", ram[a+i])};
    return r;
  endfunction

  task automatic guard_ok(input int a, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++)
      if ((i < a || i > a + n) && ram[i] != FILL) bad++;
    chk(bad == 0 && ram[a+n] == 8'h00, req,
        $sformatf("%0d stray/term=%0h", bad, ram[a+n]), "0 stray/term=0");
  endtask

  task automatic run(input int a, input bool_poke, input int poke_at);
    int t = 0;
    wcount = 0; dcount = 0;
    @(negedge clk);
    start = 1; start_addr = AW'(a);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R7", $sformatf("busy=%0b", busy), "busy=1");
    while (!done && t < 5000) begin
      if (bool_poke && t == poke_at) begin
        start = 1; start_addr = AW'(a + 3);
      end
      @(negedge clk);
      start = 0;
      t++;
    end
    chk(t < 5000, "R7", "timeout", "done");
    @(negedge clk);
    chk(!done && !busy, "R7", $sformatf("done=%0b busy=%0b", done, busy), "done=0 busy=0");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = FILL;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we, "R7",
        $sformatf("%0b%0b%0b", busy, done, mem_we), "000");
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(BASE, VIN[v]);
      run(BASE, 0, 0);
      chk(grab(BASE, VIN[v].len()) == VEXP[v], (v == 3) ? "R3" : "R2",
          grab(BASE, VIN[v].len()), VEXP[v]);
      chk(wcount == VWR[v], "R8", $sformatf("%0d writes", wcount),
          $sformatf("%0d writes", VWR[v]));
      guard_ok(BASE, VIN[v].len(), "R1");
    end

    load(BASE, "");
    run(BASE, 0, 0);
    chk(wcount == 0 && dcount == 1, "R4", $sformatf("w=%0d d=%0d", wcount, dcount), "w=0 d=1");
    guard_ok(BASE, 0, "R4");

    load(BASE, "Q");
    run(BASE, 0, 0);
    chk(wcount == 0 && ram[BASE] == "Q", "R5",
        $sformatf("w=%0d b=%c", wcount, ram[BASE]), "w=0 b=Q");

    load(BASE, "I Love Lucy");
    run(BASE, 1, 9);
    chk(grab(BASE, 11) == "Lucy Love I", "R6", grab(BASE, 11), "Lucy Love I");
    chk(dcount == 1 && wcount == 18, "R6",
        $sformatf("d=%0d w=%0d", dcount, wcount), "d=1 w=18");
    guard_ok(BASE, 11, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule